// File: doc/BRIEF.md
# Sequential or Nested Interrupt Controller

This block gathers four interrupt request lines and hands a processor one request at a time, along with the number of the line that raised it. Line 0 carries program faults such as arithmetic overflow or division by zero. Line 1 is the internal timer, line 2 is the I/O controller, and line 3 signals hardware failure such as a memory parity error. A rising edge on a line marks that source as pending. The processor takes the offered source with a one-cycle acknowledge and reports the end of its handler with a one-cycle end-of-service strobe.

A mode input selects between two service policies.

- **Sequential mode:** the processor is never offered a new source while one is in service. Pending sources are offered in the order their edges arrived.
- **Nested mode:** line numbers are priorities, with 3 the highest. A pending source strictly above the one in service is offered at once, and taking it pushes the interrupted source onto a stack. End of service pops the stack, so the interrupted source becomes the active one again.

Top module: `irq_seqnest_ctrl`

## Requirements
- R1: After reset, `irqOut` is 0 and `svcValid` is 0.
- R2: A line becomes pending on a 0-to-1 transition sampled at a clock edge, and the request shows on `irqOut` after that edge. A line held high causes one request only.
- R3: In sequential mode, `irqOut` stays 0 while `svcValid` is 1.
- R4: In sequential mode, sources are offered in arrival order. When edges arrive in the same cycle, the lower line number is offered first.
- R5: In nested mode, `irqSrc` is the highest-numbered pending line. `irqOut` is 1 only when nothing is in service or that line is numerically greater than `svcSrc`.
- R6: `ack` sampled while `irqOut` is 1 makes `irqSrc` the in-service source (`svcValid`=1, `svcSrc`=that line) and clears its pending state. `ack` sampled while `irqOut` is 0 changes nothing.
- R7: In nested mode, ending a preempting service makes the source it interrupted the in-service source again.
- R8: `eos` sampled while `svcValid` is 0 is ignored.
- R9: The mode input is adopted only at a clock edge where `svcValid` is 0. While a service is active, the previous mode keeps governing.
- R10: When `ack` and `eos` are sampled together while a source is in service and `irqOut` is 1, the ended source is discarded and the granted one becomes active. The stack of preempted sources is unchanged.
- R11: A rising edge on a line that is already pending is absorbed. It does not cause a second service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLine | input | 4 | Request lines: 0 program fault, 1 timer, 2 I/O, 3 hardware failure |
| nestMode | input | 1 | 1 selects nested priority service, 0 selects sequential service |
| ack | input | 1 | Processor takes the offered source (one-cycle pulse) |
| eos | input | 1 | Processor finished the current handler (one-cycle pulse) |
| irqOut | output | 1 | Request to the processor |
| irqSrc | output | 2 | Line number being offered; meaningful when `irqOut` is 1 |
| svcValid | output | 1 | A source is in service |
| svcSrc | output | 2 | Line number in service; meaningful when `svcValid` is 1 |

## Verification
Two events can land on the same clock edge: an acknowledge that grants a preempting source, and an end-of-service strobe for the source being preempted. The bench provokes this in nested mode by raising line 3 while line 2 is served above a stacked line 1, then pulsing `ack` and `eos` together. It judges the result by checking that line 3 becomes active and that the next end of service returns to line 1, not line 2. Random traffic with random mode changes then compares every cycle against a queue-and-stack reference model. That traffic also produces coincident edges, acknowledges and strobes in sequential mode.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // strobes from control to datapath, one clock edge each
  typedef struct packed {
    logic grant;      // offered source becomes active
    logic push;       // current active saved on the preemption stack
    logic pop;        // stack top becomes active again
    logic retire;     // service ends with nothing to resume
    logic latchMode;  // mode input may be adopted
  } ctlStrobe_t;
endpackage

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int STACK_DEPTH = 4,
  localparam int IDW = $clog2(NUM_SRC),
  localparam int CW  = $clog2(NUM_SRC + 1),
  localparam int SPW = $clog2(STACK_DEPTH + 1),
  localparam int SIW = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLine,
  input  logic               nestMode,
  input  ctlStrobe_t         strb,
  input  logic [IDW-1:0]     grantSrc,
  output logic               modeQ,
  output logic [NUM_SRC-1:0] pendQ,
  output logic [IDW-1:0]     headSrc,
  output logic               qEmpty,
  output logic               actValid,
  output logic [IDW-1:0]     actSrc,
  output logic               stackEmpty,
  output logic [SPW-1:0]     stkDepth
);
  logic [NUM_SRC-1:0] lineQ;
  logic [NUM_SRC-1:0] newly;
  logic [NUM_SRC-1:0] pendNext;
  logic [IDW-1:0]     arrQ   [NUM_SRC];
  logic [IDW-1:0]     arrNext[NUM_SRC];
  logic [CW-1:0]      cntQ, cntNext;
  logic [IDW-1:0]     stk    [STACK_DEPTH];
  logic [SPW-1:0]     sp;
  logic [IDW-1:0]     stkTop;

  // edge capture; an edge on an already pending line is absorbed
  assign newly = irqLine & ~lineQ & ~pendQ;

  always_comb begin
    pendNext = pendQ | newly;
    if (strb.grant) pendNext[grantSrc] = 1'b0;
  end

  // arrival-order queue: delete granted entry with compaction, then append
  always_comb begin
    logic found;
    found   = 1'b0;
    cntNext = cntQ;
    for (int i = 0; i < NUM_SRC; i++) arrNext[i] = arrQ[i];
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strb.grant && !found && (CW'(i) < cntQ) && (arrQ[i] == grantSrc))
        found = 1'b1;
      if (found)
        arrNext[i] = (i < NUM_SRC - 1) ? arrQ[(i + 1) % NUM_SRC] : '0;
    end
    if (found) cntNext = cntNext - 1'b1;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (newly[s]) begin
        arrNext[cntNext[IDW-1:0]] = IDW'(s);
        cntNext = cntNext + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ <= '0;
      pendQ <= '0;
      cntQ  <= '0;
      for (int i = 0; i < NUM_SRC; i++) arrQ[i] <= '0;
    end else begin
      lineQ <= irqLine;
      pendQ <= pendNext;
      cntQ  <= cntNext;
      for (int i = 0; i < NUM_SRC; i++) arrQ[i] <= arrNext[i];
    end
  end

  assign headSrc = arrQ[0];
  assign qEmpty  = (cntQ == '0);

  // preemption stack and active source
  assign stkTop     = stk[SIW'(sp - 1'b1)];
  assign stackEmpty = (sp == '0);
  assign stkDepth   = sp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp       <= '0;
      actValid <= 1'b0;
      actSrc   <= '0;
      modeQ    <= 1'b0;
      for (int i = 0; i < STACK_DEPTH; i++) stk[i] <= '0;
    end else begin
      if (strb.latchMode) modeQ <= nestMode;
      if (strb.push) begin
        stk[SIW'(sp)] <= actSrc;
        sp            <= sp + 1'b1;
      end
      if (strb.grant) begin
        actValid <= 1'b1;
        actSrc   <= grantSrc;
      end else if (strb.pop) begin
        actSrc <= stkTop;
        sp     <= sp - 1'b1;
      end else if (strb.retire) begin
        actValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int IDW = $clog2(NUM_SRC)
) (
  input  logic               modeQ,
  input  logic [NUM_SRC-1:0] pendQ,
  input  logic [IDW-1:0]     headSrc,
  input  logic               qEmpty,
  input  logic               actValid,
  input  logic [IDW-1:0]     actSrc,
  input  logic               stackEmpty,
  input  logic               ack,
  input  logic               eos,
  output logic               irqOut,
  output logic [IDW-1:0]     irqSrc,
  output ctlStrobe_t         strb
);
  logic [IDW-1:0] best;
  logic           anyPend;
  logic           eosHit;

  always_comb begin
    best = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (pendQ[s]) best = IDW'(s);
  end
  assign anyPend = |pendQ;

  always_comb begin
    if (modeQ) begin
      irqOut = anyPend && (!actValid || (best > actSrc));
      irqSrc = best;
    end else begin
      irqOut = !actValid && !qEmpty;
      irqSrc = headSrc;
    end
  end

  assign eosHit         = eos && actValid;
  assign strb.grant     = ack && irqOut;
  assign strb.push      = strb.grant && actValid && !eosHit;
  assign strb.pop       = eosHit && !stackEmpty && !strb.grant;
  assign strb.retire    = eosHit && stackEmpty && !strb.grant;
  assign strb.latchMode = !actValid;
endmodule

// File: rtl/irq_seqnest_ctrl.sv
module irq_seqnest_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int STACK_DEPTH = 4,
  localparam int IDW = $clog2(NUM_SRC),
  localparam int SPW = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLine,
  input  logic               nestMode,
  input  logic               ack,
  input  logic               eos,
  output logic               irqOut,
  output logic [IDW-1:0]     irqSrc,
  output logic               svcValid,
  output logic [IDW-1:0]     svcSrc
);
  ctlStrobe_t         strb;
  logic               modeQ;
  logic [NUM_SRC-1:0] pendQ;
  logic [IDW-1:0]     headSrc;
  logic               qEmpty;
  logic               stackEmpty;
  logic [SPW-1:0]     stkDepth;

  intc_datapath #(.NUM_SRC(NUM_SRC), .STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .nestMode(nestMode),
    .strb(strb), .grantSrc(irqSrc), .modeQ(modeQ), .pendQ(pendQ),
    .headSrc(headSrc), .qEmpty(qEmpty), .actValid(svcValid),
    .actSrc(svcSrc), .stackEmpty(stackEmpty), .stkDepth(stkDepth)
  );

  intc_control #(.NUM_SRC(NUM_SRC)) u_ctl (
    .modeQ(modeQ), .pendQ(pendQ), .headSrc(headSrc), .qEmpty(qEmpty),
    .actValid(svcValid), .actSrc(svcSrc), .stackEmpty(stackEmpty),
    .ack(ack), .eos(eos), .irqOut(irqOut), .irqSrc(irqSrc), .strb(strb)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int IDW = 2,
  parameter int SPW = 3
) (
  input logic           clk,
  input logic           rstN,
  input logic           ack,
  input logic           eos,
  input logic           irqOut,
  input logic [IDW-1:0] irqSrc,
  input logic           svcValid,
  input logic [IDW-1:0] svcSrc,
  input logic           modeQ,
  input logic [SPW-1:0] stkDepth
);
  AST_SEQ_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!modeQ && svcValid) |-> !irqOut); // R3

  AST_NEST_STRICTLY_HIGHER: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ && svcValid && irqOut) |-> (irqSrc > svcSrc)); // R5

  AST_GRANT_TAKES_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqOut) |=> (svcValid && svcSrc == $past(irqSrc))); // R6

  AST_IDLE_EOS_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (eos && !svcValid && !(ack && irqOut)) |=> !svcValid); // R8

  AST_MODE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    svcValid |=> $stable(modeQ)); // R9

  AST_SWAP_KEEPS_STACK: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqOut && eos && svcValid) |=> $stable(stkDepth)); // R10
endmodule

bind irq_seqnest_ctrl intc_checker #(.IDW(IDW), .SPW(SPW)) u_chk (
  .clk(clk), .rstN(rstN), .ack(ack), .eos(eos), .irqOut(irqOut),
  .irqSrc(irqSrc), .svcValid(svcValid), .svcSrc(svcSrc),
  .modeQ(modeQ), .stkDepth(stkDepth)
);

// File: tb/sim_irq_seqnest_ctrl.sv
`timescale 1ns/1ps
module sim_irq_seqnest_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] irqLine = '0;
  logic       nestMode = 1'b0;
  logic       ack = 1'b0;
  logic       eos = 1'b0;
  logic       irqOut;
  logic [1:0] irqSrc;
  logic       svcValid;
  logic [1:0] svcSrc;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  irq_seqnest_ctrl u0 (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .nestMode(nestMode),
    .ack(ack), .eos(eos), .irqOut(irqOut), .irqSrc(irqSrc),
    .svcValid(svcValid), .svcSrc(svcSrc)
  );

  always #4 clk = ~clk;

  // reference model: arrival list, preemption list, pending set
  int  mq[$];
  int  mstk[$];
  bit  mPend[4];
  bit  mPrev[4];
  bit  mActV;
  int  mAct;
  bit  mMode;

  function automatic void modelOut(output bit o, output int s);
    int best;
    bit any;
    best = 0; any = 0;
    for (int i = 0; i < 4; i++) if (mPend[i]) begin best = i; any = 1; end
    if (mMode) begin
      o = any && (!mActV || best > mAct);
      s = best;
    end else begin
      o = !mActV && (mq.size() > 0);
      s = (mq.size() > 0) ? mq[0] : 0;
    end
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete(); mstk.delete();
      for (int i = 0; i < 4; i++) begin mPend[i] = 0; mPrev[i] = 0; end
      mActV = 0; mAct = 0; mMode = 0;
    end else begin
      bit o, g, eh, oldV;
      int s;
      bit nw[4];
      modelOut(o, s);
      g = ack && o;
      eh = eos && mActV;
      oldV = mActV;
      for (int i = 0; i < 4; i++) nw[i] = irqLine[i] && !mPrev[i] && !mPend[i];
      if (g) begin
        foreach (mq[k]) if (mq[k] == s) begin mq.delete(k); break; end
        mPend[s] = 0;
      end
      for (int i = 0; i < 4; i++) if (nw[i]) begin mq.push_back(i); mPend[i] = 1; end
      if (g) begin
        if (mActV && !eh) mstk.push_back(mAct);
        mAct = s; mActV = 1;
      end else if (eh) begin
        if (mstk.size() > 0) mAct = mstk.pop_back();
        else mActV = 0;
      end
      if (!oldV) mMode = nestMode;
      for (int i = 0; i < 4; i++) mPrev[i] = irqLine[i];
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit o; int s;
      modelOut(o, s);
      nChecks++;
      if (irqOut !== o || svcValid !== mActV ||
          (o && irqSrc !== 2'(s)) || (mActV && svcSrc !== 2'(mAct))) begin
        nFail++;
        $display("FAIL R3 R4 R5 R6 R7 model: irq=%0b src=%0d svc=%0b/%0d expected irq=%0b src=%0d svc=%0b/%0d",
                 irqOut, irqSrc, svcValid, svcSrc, o, s, mActV, mAct);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] ln, input bit nm, input bit ak, input bit es);
    irqLine = ln; nestMode = nm; ack = ak; eos = es;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nChecks + 1 - nFail, nChecks + 1);
    $finish;
  end

  initial begin
    int order[4];
    order = '{0, 1, 3, 2};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(irqOut, 0, "R1 irqOut");
    chk(svcValid, 0, "R1 svcValid");

    // sequential ordering
    step(4'b0100, 0, 0, 0);
    chk(irqOut, 1, "R2 edge request");
    chk(irqSrc, 2, "R2 edge source");
    step(4'b0001, 0, 0, 0);
    step(4'b1010, 0, 0, 0);
    step(4'b0001, 0, 0, 0);             // R11 edge on pending line 0
    step(4'b0000, 0, 1, 0);
    chk(svcSrc, 2, "R6 grant source");
    chk(irqOut, 0, "R3 busy hold off");
    step(4'b0100, 0, 0, 0);
    chk(irqOut, 0, "R3 busy with new edge");
    step(4'b0000, 0, 0, 1);
    for (int k = 0; k < 4; k++) begin
      chk(irqSrc, order[k], "R4 arrival order");
      step(4'b0000, 0, 1, 0);
      chk(svcSrc, order[k], "R4 served order");
      step(4'b0000, 0, 0, 1);
    end
    chk(irqOut, 0, "R11 no duplicate");
    step(4'b0000, 0, 0, 1);
    chk(svcValid, 0, "R8 idle eos");
    chk(irqOut, 0, "R8 idle eos request");

    // held level
    step(4'b1000, 0, 0, 0);
    step(4'b1000, 0, 1, 0);
    step(4'b1000, 0, 0, 1);
    step(4'b1000, 0, 0, 0);
    chk(irqOut, 0, "R2 level held");
    step(4'b0000, 0, 0, 0);

    // mode change while busy
    step(4'b0010, 0, 0, 0);
    step(4'b0000, 0, 1, 0);
    step(4'b1000, 1, 0, 0);
    chk(irqOut, 0, "R9 mode not adopted while busy");
    step(4'b0000, 1, 0, 1);
    chk(irqSrc, 3, "R9 idle source");
    step(4'b0000, 1, 1, 0);
    step(4'b0000, 1, 0, 1);

    // nesting
    step(4'b0010, 1, 0, 0);
    step(4'b0000, 1, 1, 0);
    chk(svcSrc, 1, "R6 nested grant");
    step(4'b0001, 1, 0, 0);
    chk(irqOut, 0, "R5 lower blocked");
    step(4'b0000, 1, 0, 0);
    step(4'b0010, 1, 0, 0);
    chk(irqOut, 0, "R5 equal blocked");
    step(4'b1000, 1, 0, 0);
    chk(irqOut, 1, "R5 higher offered");
    chk(irqSrc, 3, "R5 highest pending");
    step(4'b0000, 1, 1, 0);
    chk(svcSrc, 3, "R6 preempt grant");
    step(4'b0100, 1, 0, 0);
    chk(irqOut, 0, "R5 below active");
    step(4'b0000, 1, 0, 1);
    chk(svcSrc, 1, "R7 resume interrupted");
    chk(irqSrc, 2, "R5 next higher");
    step(4'b0000, 1, 1, 0);
    step(4'b0000, 1, 1, 0);
    chk(svcSrc, 2, "R6 ack without request ignored");
    step(4'b1000, 1, 0, 0);
    step(4'b0000, 1, 1, 1);
    chk(svcSrc, 3, "R10 swap grant");
    step(4'b0000, 1, 0, 1);
    chk(svcSrc, 1, "R10 ended source dropped");
    chk(irqOut, 0, "R5 equal pending blocked");
    step(4'b0000, 1, 0, 1);
    chk(svcValid, 0, "R7 stack drained");

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] ln;
      for (int b = 0; b < 4; b++) ln[b] = ($urandom_range(0, 5) == 0);
      step(ln, (n / 500) % 2 == 1 ? 1'b1 : ($urandom_range(0, 40) == 0),
           $urandom_range(0, 9) < 4, $urandom_range(0, 9) < 2);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule